// File: doc/BRIEF.md
# Supervisor Reset Pulse Generator

This block produces the system reset for a processor supervisor. It merges three reset sources into a single reset state. The first is an undervoltage flag from an external comparator, synchronous to the block clock. The second is an active-low manual reset pin, which may be asynchronous. The third is a single-cycle timeout request from a watchdog. While any source is active the reset is held. Once every source has cleared, the reset is held for a fixed number of clock cycles and then released.

The manual reset pin passes through a synchronizer and then a minimum-width filter. Short low glitches are discarded, and a low level that lasts long enough is accepted as a reset request. The reset state drives two outputs, one active high and one active low. A one-cycle strobe and a cause code report what started each new reset. All time windows are parameters counted in clock cycles: `ACTIVE_CYCLES` (P) and `MR_MIN_LOW` (N).

Top module: `supv_reset_gen`

## Requirements
- R1: While `arstN` is low, `rstOut`=1, `rstOutN`=0, `causeValid`=0 and `causeCode`=0 (power-on). If no source is active after `arstN` rises, `rstOut` stays 1 through the P-th rising clock edge after release and falls at the (P+1)-th.
- R2: `uvIn` sampled high at a rising edge sets `rstOut` to 1 from that edge on. The output stays asserted for as long as `uvIn` is high.
- R3: Let the last rising edge at which any source is seen active be edge E. Then `rstOut` stays 1 through edge E+P and falls at edge E+P+1. A source that appears during this stretch restarts the full P-cycle hold.
- R4: A one-cycle `wdTimeout` pulse sampled at an edge asserts `rstOut` at that edge, and the reset is then stretched as in R3.
- R5: A low level on `mrN` that is sampled at fewer than N consecutive rising edges is ignored, and `rstOut` stays 0.
- R6: A low level on `mrN` sampled at N or more consecutive edges, beginning at edge 1, asserts `rstOut` at edge N+3 (two synchronizer stages, the width filter, then the reset register).
- R7: Let `mrN` be sampled high again at edge 1 after an accepted low. Then `rstOut` falls at edge P+4.
- R8: `rstOutN` is always the complement of `rstOut`.
- R9: At the edge where `rstOut` goes from 0 to 1, `causeValid` pulses high for one cycle. At the same edge `causeCode` is loaded with the starting source: 1 undervoltage, 2 manual, 3 watchdog. If sources start together the priority is undervoltage, then manual, then watchdog. A source that arrives while reset is already asserted produces no pulse. `causeCode` holds its value until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arstN | input | 1 | Asynchronous active-low initialization |
| uvIn | input | 1 | Undervoltage flag, synchronous, active high |
| mrN | input | 1 | Manual reset pin, active low, asynchronous |
| wdTimeout | input | 1 | Watchdog timeout request, single-cycle pulse |
| rstOut | output | 1 | Reset, active high |
| rstOutN | output | 1 | Reset, active low |
| causeValid | output | 1 | One-cycle strobe when a new reset starts |
| causeCode | output | 2 | Cause of the most recent reset start |

## Verification
The undervoltage and watchdog sources act at the edge that samples them. A manual reset takes effect at edge N+3 after the pin first goes low. Release follows P+1 edges after the last edge that saw a source, which is edge P+4 after the pin returns high for a manual reset. The bench drives inputs on falling edges and counts rising edges since release. For each stimulus it queues the expected output values tagged with the cycle number at which they fall due. A monitor compares the outputs on each falling edge against the queue. Each scenario checks both sides of every boundary: the last asserted cycle and the first released cycle, a low pulse of N-1 samples and one of exactly N.

// File: rtl/supv_reset_pkg.sv
package supv_reset_pkg;

  typedef enum logic [1:0] {
    CAUSE_POWER  = 2'd0,
    CAUSE_UV     = 2'd1,
    CAUSE_MANUAL = 2'd2,
    CAUSE_WDOG   = 2'd3
  } cause_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadActive;   // reload the hold counter to its full period
    logic decActive;    // count the hold counter down by one
  } ctrlStrobe_t;

endpackage

// File: rtl/supv_reset_dp.sv
module supv_reset_dp
  import supv_reset_pkg::*;
#(
  parameter int ACTIVE_CYCLES = 200,
  parameter int MR_MIN_LOW    = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic        clk,
  input  logic        arstN,
  input  logic        mrN,
  input  ctrlStrobe_t strobe,
  output logic        mrAccepted,
  output logic        activeDone
);

  localparam int CW = $clog2(ACTIVE_CYCLES + 1);
  localparam logic [CW-1:0] ACTIVE_LOAD = CW'(ACTIVE_CYCLES);

  // Synchronizer for the asynchronous manual reset pin
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   mrSync;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) syncQ <= '1;
    else        syncQ <= {syncQ[SYNC_STAGES-2:0], mrN};
  end
  assign mrSync = syncQ[SYNC_STAGES-1];

  // Minimum-width filter: accept after MR_MIN_LOW consecutive low samples
  generate
    if (MR_MIN_LOW <= 1) begin : g_noFilter
      always_ff @(posedge clk or negedge arstN) begin
        if (!arstN) mrAccepted <= 1'b0;
        else        mrAccepted <= ~mrSync;
      end
    end else begin : g_widthFilter
      localparam int LW = $clog2(MR_MIN_LOW);
      localparam logic [LW-1:0] LOW_LAST = LW'(MR_MIN_LOW - 1);
      logic [LW-1:0] lowCnt;

      always_ff @(posedge clk or negedge arstN) begin
        if (!arstN) begin
          lowCnt     <= '0;
          mrAccepted <= 1'b0;
        end else if (mrSync) begin
          lowCnt     <= '0;
          mrAccepted <= 1'b0;
        end else begin
          if (lowCnt == LOW_LAST) mrAccepted <= 1'b1;
          else                    lowCnt     <= lowCnt + 1'b1;
        end
      end
    end
  endgenerate

  // Reset hold counter
  logic [CW-1:0] activeCnt;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)                 activeCnt <= ACTIVE_LOAD;
    else if (strobe.loadActive) activeCnt <= ACTIVE_LOAD;
    else if (strobe.decActive)  activeCnt <= activeCnt - 1'b1;
  end

  assign activeDone = (activeCnt == '0);

endmodule

// File: rtl/supv_reset_ctrl.sv
module supv_reset_ctrl
  import supv_reset_pkg::*;
(
  input  logic        clk,
  input  logic        arstN,
  input  logic        uvIn,
  input  logic        mrAccepted,
  input  logic        wdTimeout,
  input  logic        activeDone,
  output ctrlStrobe_t strobe,
  output logic        rstActive,
  output logic        causeValid,
  output cause_e      causeCode
);

  logic   causeNow;
  logic   rstQ;
  logic   startNow;
  cause_e nextCode;

  always_comb begin
    causeNow          = uvIn | mrAccepted | wdTimeout;
    startNow          = causeNow & ~rstQ;
    strobe.loadActive = causeNow;
    strobe.decActive  = ~causeNow & ~activeDone;
    if (uvIn)            nextCode = CAUSE_UV;
    else if (mrAccepted) nextCode = CAUSE_MANUAL;
    else                 nextCode = CAUSE_WDOG;
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      rstQ       <= 1'b1;
      causeValid <= 1'b0;
      causeCode  <= CAUSE_POWER;
    end else begin
      rstQ       <= causeNow | ~activeDone;
      causeValid <= startNow;
      if (startNow) causeCode <= nextCode;
    end
  end

  assign rstActive = rstQ;

endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
  import supv_reset_pkg::*;
#(
  parameter int ACTIVE_CYCLES = 200,
  parameter int MR_MIN_LOW    = 8
) (
  input  logic       clk,
  input  logic       arstN,
  input  logic       uvIn,
  input  logic       mrN,
  input  logic       wdTimeout,
  output logic       rstOut,
  output logic       rstOutN,
  output logic       causeValid,
  output logic [1:0] causeCode
);

  ctrlStrobe_t strobe;
  logic        mrAccepted;
  logic        activeDone;
  logic        rstActive;
  cause_e      codeQ;

  supv_reset_dp #(
    .ACTIVE_CYCLES(ACTIVE_CYCLES),
    .MR_MIN_LOW   (MR_MIN_LOW),
    .SYNC_STAGES  (2)
  ) u_dp (
    .clk       (clk),
    .arstN     (arstN),
    .mrN       (mrN),
    .strobe    (strobe),
    .mrAccepted(mrAccepted),
    .activeDone(activeDone)
  );

  supv_reset_ctrl u_ctrl (
    .clk       (clk),
    .arstN     (arstN),
    .uvIn      (uvIn),
    .mrAccepted(mrAccepted),
    .wdTimeout (wdTimeout),
    .activeDone(activeDone),
    .strobe    (strobe),
    .rstActive (rstActive),
    .causeValid(causeValid),
    .causeCode (codeQ)
  );

  assign rstOut    = rstActive;
  assign rstOutN   = ~rstActive;
  assign causeCode = codeQ;

endmodule

// File: rtl/supv_reset_gen_chk.sv
module supv_reset_gen_chk (
  input logic       clk,
  input logic       arstN,
  input logic       uvIn,
  input logic       wdTimeout,
  input logic       rstOut,
  input logic       rstOutN,
  input logic       causeValid,
  input logic [1:0] causeCode
);

  assert_uv_holds_R2: assert property (@(posedge clk) disable iff (!arstN)
    uvIn |=> rstOut);

  assert_wd_asserts_R4: assert property (@(posedge clk) disable iff (!arstN)
    wdTimeout |=> rstOut);

  assert_no_early_release_R3: assert property (@(posedge clk) disable iff (!arstN)
    $fell(rstOut) |-> (!$past(uvIn) && !$past(wdTimeout)));

  assert_complement_R8: assert property (@(posedge clk) disable iff (!arstN)
    rstOut != rstOutN);

  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!arstN)
    causeValid |=> !causeValid);

  assert_strobe_on_start_R9: assert property (@(posedge clk) disable iff (!arstN)
    causeValid |-> (rstOut && !$past(rstOut) && causeCode != 2'd0));

endmodule

bind supv_reset_gen supv_reset_gen_chk u_chk (
  .clk       (clk),
  .arstN     (arstN),
  .uvIn      (uvIn),
  .wdTimeout (wdTimeout),
  .rstOut    (rstOut),
  .rstOutN   (rstOutN),
  .causeValid(causeValid),
  .causeCode (causeCode)
);

// File: tb/supv_reset_gen_tb.sv
module supv_reset_gen_tb;

  localparam int P = 20;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       arstN = 1'b0;
  logic       uvIn = 1'b0;
  logic       mrN = 1'b1;
  logic       wdTimeout = 1'b0;
  logic       rstOut, rstOutN, causeValid;
  logic [1:0] causeCode;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  supv_reset_gen #(.ACTIVE_CYCLES(P), .MR_MIN_LOW(N)) u_dut (
    .clk(clk), .arstN(arstN), .uvIn(uvIn), .mrN(mrN), .wdTimeout(wdTimeout),
    .rstOut(rstOut), .rstOutN(rstOutN), .causeValid(causeValid), .causeCode(causeCode)
  );

  typedef struct {
    int         cyc;
    bit         rst;
    bit         chkValid;
    bit         valid;
    bit         chkCode;
    logic [1:0] code;
    string      tag;
  } exp_t;

  exp_t expQ[$];
  exp_t cur;

  always @(posedge clk) if (arstN) cyc <= cyc + 1;

  task automatic push(int c, bit r, bit cv, bit v, bit cc, logic [1:0] code, string tag);
    exp_t e;
    e.cyc = c; e.rst = r; e.chkValid = cv; e.valid = v;
    e.chkCode = cc; e.code = code; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic waitTo(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic drain();
    while (expQ.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  // Monitor: compare against queued expectations away from the active edge
  always @(negedge clk) begin
    if (arstN) begin
      nChecks++;
      if (rstOutN !== ~rstOut) begin
        nFails++;
        $display("FAIL R8 cyc %0d: rstOutN=%0b expected %0b", cyc, rstOutN, ~rstOut);
      end
      while (expQ.size() > 0 && expQ[0].cyc <= cyc) begin
        cur = expQ.pop_front();
        nChecks++;
        if (cur.cyc < cyc) begin
          nFails++;
          $display("FAIL %s: check for cyc %0d missed, actual cyc %0d expected %0d", cur.tag, cur.cyc, cyc, cur.cyc);
        end else begin
          if (rstOut !== cur.rst) begin
            nFails++;
            $display("FAIL %s cyc %0d: rstOut=%0b expected %0b", cur.tag, cyc, rstOut, cur.rst);
          end
          if (cur.chkValid && causeValid !== cur.valid) begin
            nFails++;
            $display("FAIL %s cyc %0d: causeValid=%0b expected %0b", cur.tag, cyc, causeValid, cur.valid);
          end
          if (cur.chkCode && causeCode !== cur.code) begin
            nFails++;
            $display("FAIL %s cyc %0d: causeCode=%0d expected %0d", cur.tag, cyc, causeCode, cur.code);
          end
        end
      end
    end
  end

  // Watchdog on the bench itself
  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not finish, actual cyc %0d expected < 20000", cyc);
    finishRun();
  end

  initial begin
    int c0;
    int c1;
    // R1: state during initialization
    repeat (3) @(negedge clk);
    nChecks++;
    if (rstOut !== 1'b1 || rstOutN !== 1'b0 || causeValid !== 1'b0 || causeCode !== 2'd0) begin
      nFails++;
      $display("FAIL R1 init: rst=%0b rstN=%0b valid=%0b code=%0d expected 1 0 0 0",
               rstOut, rstOutN, causeValid, causeCode);
    end
    push(P,     1, 1, 0, 1, 2'd0, "R1 power-up hold last cycle");
    push(P + 1, 0, 1, 0, 1, 2'd0, "R1 power-up release");
    arstN = 1'b1;
    drain();

    // R2/R3: undervoltage for five samples
    c0 = cyc;
    push(c0 + 1,     1, 1, 1, 1, 2'd1, "R2 undervoltage assert R9 code");
    push(c0 + 2,     1, 1, 0, 1, 2'd1, "R9 strobe one cycle");
    push(c0 + 5,     1, 1, 0, 0, 2'd0, "R2 held while active");
    push(c0 + P + 5, 1, 0, 0, 0, 2'd0, "R3 stretch last cycle");
    push(c0 + P + 6, 0, 1, 0, 1, 2'd1, "R3 release R9 code holds");
    uvIn = 1'b1;
    waitTo(c0 + 5);
    uvIn = 1'b0;
    drain();

    // R4/R3: watchdog pulse, then retrigger during the stretch
    c0 = cyc;
    push(c0 + 1,      1, 1, 1, 1, 2'd3, "R4 watchdog assert R9 code");
    push(c0 + 2,      1, 1, 0, 0, 2'd0, "R9 strobe one cycle");
    push(c0 + 11,     1, 1, 0, 1, 2'd3, "R9 no strobe on retrigger");
    push(c0 + P + 2,  1, 0, 0, 0, 2'd0, "R3 retrigger extends hold");
    push(c0 + P + 11, 1, 0, 0, 0, 2'd0, "R3 retrigger last cycle");
    push(c0 + P + 12, 0, 0, 0, 0, 2'd0, "R3 retrigger release");
    wdTimeout = 1'b1;
    waitTo(c0 + 1);
    wdTimeout = 1'b0;
    waitTo(c0 + 10);
    wdTimeout = 1'b1;
    waitTo(c0 + 11);
    wdTimeout = 1'b0;
    drain();

    // R5: manual low for N-1 samples is ignored
    c0 = cyc;
    for (int k = 1; k <= N + 8; k++) push(c0 + k, 0, 1, 0, 0, 2'd0, "R5 short manual glitch");
    mrN = 1'b0;
    waitTo(c0 + N - 1);
    mrN = 1'b1;
    drain();

    // R6/R7: manual held low, accepted, then released
    c0 = cyc;
    c1 = c0 + 15;
    push(c0 + N + 2, 0, 1, 0, 0, 2'd0, "R6 not before N+3");
    push(c0 + N + 3, 1, 1, 1, 1, 2'd2, "R6 manual assert R9 code");
    push(c0 + N + 4, 1, 1, 0, 0, 2'd0, "R9 strobe one cycle");
    mrN = 1'b0;
    waitTo(c1);
    push(c1 + P + 3, 1, 0, 0, 0, 2'd0, "R7 hold last cycle");
    push(c1 + P + 4, 0, 0, 0, 1, 2'd2, "R7 release");
    mrN = 1'b1;
    drain();

    // R6: exactly N low samples is accepted
    c0 = cyc;
    push(c0 + N + 3,     1, 1, 1, 1, 2'd2, "R6 minimum-width accept");
    push(c0 + N + P + 3, 1, 0, 0, 0, 2'd0, "R3 minimum-width hold");
    push(c0 + N + P + 4, 0, 0, 0, 0, 2'd0, "R3 minimum-width release");
    mrN = 1'b0;
    waitTo(c0 + N);
    mrN = 1'b1;
    drain();

    // R9: undervoltage beats watchdog at the same edge
    c0 = cyc;
    push(c0 + 1,     1, 1, 1, 1, 2'd1, "R9 priority undervoltage over watchdog");
    push(c0 + P + 1, 1, 0, 0, 0, 2'd0, "R3 hold last cycle");
    push(c0 + P + 2, 0, 0, 0, 0, 2'd0, "R3 release");
    uvIn = 1'b1;
    wdTimeout = 1'b1;
    waitTo(c0 + 1);
    uvIn = 1'b0;
    wdTimeout = 1'b0;
    drain();

    // R9: manual beats watchdog at the same edge
    c0 = cyc;
    c1 = c0 + 15;
    push(c0 + N + 3, 1, 1, 1, 1, 2'd2, "R9 priority manual over watchdog");
    mrN = 1'b0;
    waitTo(c0 + N + 2);
    wdTimeout = 1'b1;
    waitTo(c0 + N + 3);
    wdTimeout = 1'b0;
    waitTo(c1);
    push(c1 + P + 4, 0, 1, 0, 1, 2'd2, "R7 release after priority case");
    mrN = 1'b1;
    drain();

    finishRun();
  end

endmodule